// File: doc/BRIEF.md
# Host Mailbox FIFO Register Interface

This block connects a 32-bit host register bus to a byte-wide link toward a system-management microcontroller. The host sees three word registers in a 32-byte window: an interrupt-control register, a data register and a status register. Bytes the host writes to the data register queue in a transmit FIFO and leave on a valid/ready byte port. Bytes arriving from the controller queue in a receive FIFO and are returned by host reads of the data register. In both directions the byte sits in bits 15:8 of the data word.

Four conditions are tracked: transmit FIFO empty, transmit FIFO not full, receive FIFO not empty, and a sticky receive-overflow flag. Each condition has a request bit that latches when the condition rises, and a mask bit. The single interrupt output is raised while any source has both its request and its mask set. Host software clears requests by writing ones, and acknowledges a received byte by writing the receive-not-empty bit of the status register.

Top module: `mbox_regif`

## Requirements
- R1: The byte address bits 4:2 select the register: word 0 (byte 0x00) is interrupt control, word 1 (0x04) is data, word 2 (0x08) is status; words 3 to 7 read as zero and writes to them change nothing.
- R2: A data-register write while the transmit FIFO is not full queues bits 15:8 of the write data; queued bytes appear on `tx_data` with `tx_valid` high in write order, and each is removed on a cycle where `tx_valid` and `tx_ready` are both high.
- R3: The transmit FIFO holds 8 bytes; a data-register write while it is full is dropped and the queued bytes are unchanged.
- R4: A data-register read while the receive FIFO holds bytes returns the oldest byte in bits 15:8 with all other bits zero and removes it; a read while the receive FIFO is empty returns zero and removes nothing.
- R5: The status register reads the live conditions in bits 3:0: bit 0 transmit FIFO empty, bit 1 transmit FIFO not full, bit 2 receive FIFO not empty, bit 3 receive overflow; upper bits read zero.
- R6: A byte arriving on `rx_valid` while the receive FIFO already holds 8 bytes is discarded and sets the overflow flag, which stays set until a status write with bit 3 set clears it.
- R7: Interrupt-control bits 3:0 are request bits for the four sources in the order of R5; a request bit becomes 1 on the cycle after its condition goes from 0 to 1 and otherwise holds.
- R8: Writing a 1 to bit n (n in 0..3) of the status register or of the interrupt-control register clears request n; writing status bit 2 acknowledges the received byte, leaving request 2 clear until receive-not-empty rises again. Zero bits leave requests unchanged.
- R9: Interrupt-control bits 7:4 are the masks for sources 0 to 3, loaded by every interrupt-control write; `irq` is high exactly when some source has its request bit and its mask bit both 1.
- R10: After reset both FIFOs are empty, all requests, masks and the overflow flag are zero, `irq` and `tx_valid` are low, and no request latches from the reset-state conditions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Byte address inside the register window |
| bus_wr | input | 1 | Register write strobe, one cycle per access |
| bus_rd | input | 1 | Register read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd`, zero otherwise |
| irq | output | 1 | Interrupt to the host |
| tx_valid | output | 1 | A transmit byte is offered to the controller link |
| tx_data | output | 8 | Oldest transmit byte |
| tx_ready | input | 1 | Controller link takes the offered byte |
| rx_valid | input | 1 | Controller link delivers a byte this cycle |
| rx_data | input | 8 | Byte delivered by the controller link |

## Verification
The hardest state to reach from the ports is all four requests set at once, because the two transmit requests only latch when the conditions return after being driven away: the transmit FIFO must be filled past full and then drained completely, while the receive side is pushed past its depth to raise overflow. The bench builds that state in this order, then sweeps all sixteen mask values and checks `irq` against each, and finally clears the sources one at a time through both registers. Ignored writes and empty reads are checked by reading the FIFO contents back through the normal ports afterwards.

// File: rtl/mbox_pkg.sv
// Shared constants for the host mailbox register interface.
// Assumes four interrupt sources in a fixed bit order that software decodes.
package mbox_pkg;
    localparam int NUM_SRC  = 4;
    localparam int BYTE_W   = 8;
    localparam int BUS_W    = 32;
    localparam int BYTE_LSB = 8;   // byte lane inside the data word

    // Source bit positions, shared by status, request and mask fields.
    localparam int SRC_TXE  = 0;
    localparam int SRC_TXNF = 1;
    localparam int SRC_RXNE = 2;
    localparam int SRC_OVF  = 3;

    // Word indices in the register window.
    localparam logic [2:0] W_INTCTL = 3'd0;
    localparam logic [2:0] W_DATA   = 3'd1;
    localparam logic [2:0] W_STATUS = 3'd2;

    // Conditions right after reset: transmit empty and not full.
    localparam logic [NUM_SRC-1:0] COND_AT_RESET = 4'b0011;
endpackage

// File: rtl/mbox_fifo.sv
// Synchronous FIFO with occupancy count.
// Assumes push is ignored when full and pop is ignored when empty; head data
// is shown combinationally. Any DEPTH of at least 2 is supported.
module mbox_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              empty,
    output logic              full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] store [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;
    logic              do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = store[rd_ptr];

    // Storage write; no reset needed on the data array.
    always_ff @(posedge clk) begin
        if (do_push) store[wr_ptr] <= push_data;
    end

    // Pointer and count bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R3: occupancy never exceeds the depth.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R3: a push into a full FIFO without a pop leaves it full.
    p_full_push_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full);
endmodule

// File: rtl/mbox_irq.sv
// Interrupt request latches, masks and the interrupt output.
// Assumes cond is registered upstream; a request latches on the cycle after
// its condition rises, and a rise wins over a clear in the same cycle.
module mbox_irq
    import mbox_pkg::*;
#(
    parameter logic [NUM_SRC-1:0] RESET_COND = COND_AT_RESET
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] cond,
    input  logic [NUM_SRC-1:0] clr,
    input  logic               mask_we,
    input  logic [NUM_SRC-1:0] mask_in,
    output logic [NUM_SRC-1:0] req_o,
    output logic [NUM_SRC-1:0] mask_o,
    output logic               irq_o
);
    logic [NUM_SRC-1:0] prev_cond;
    logic [NUM_SRC-1:0] rise;

    assign rise  = cond & ~prev_cond;
    assign irq_o = |(req_o & mask_o);

    // Edge history, requests and masks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_cond <= RESET_COND;
            req_o     <= '0;
            mask_o    <= '0;
        end else begin
            prev_cond <= cond;
            req_o     <= (req_o & ~clr) | rise;
            if (mask_we) mask_o <= mask_in;
        end
    end

    // R7: a rising condition shows up as a set request one cycle later.
    p_latch_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((req_o & $past(rise)) == $past(rise)));

    // R8: a clear without a simultaneous rise leaves the request at zero.
    p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr & ~rise) != '0) |=> ((req_o & $past(clr & ~rise)) == '0));

    // R9: with every mask at zero the output stays low.
    p_masked_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_o == '0) |-> !irq_o);
endmodule

// File: rtl/mbox_regif.sv
// Host mailbox register interface: decodes the 32-byte register window,
// feeds the transmit FIFO from data writes, drains the receive FIFO on data
// reads, tracks the sticky overflow flag and hands conditions to the
// interrupt logic. Assumes one-cycle bus strobes and a receive link that
// never stalls (a byte offered while full is lost).
module mbox_regif
    import mbox_pkg::*;
#(
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 8,
    parameter int ADDR_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data
);
    logic [2:0]          word_idx;
    logic                wr_int, wr_data, wr_stat, rd_data;
    logic                tx_empty, tx_full, rx_empty, rx_full;
    logic [BYTE_W-1:0]   rx_head;
    logic                ovf_flag;
    logic [NUM_SRC-1:0]  cond, clr, req, mask;
    logic                unused_bus;

    assign word_idx = bus_addr[4:2];
    assign wr_int   = bus_wr && (word_idx == W_INTCTL);
    assign wr_data  = bus_wr && (word_idx == W_DATA);
    assign wr_stat  = bus_wr && (word_idx == W_STATUS);
    assign rd_data  = bus_rd && (word_idx == W_DATA);
    assign unused_bus = ^{bus_addr[1:0], bus_wdata[BUS_W-1:16]};

    mbox_fifo #(.DATA_W(BYTE_W), .DEPTH(TX_DEPTH)) u_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_data),
        .push_data (bus_wdata[BYTE_LSB +: BYTE_W]),
        .pop       (tx_ready),
        .head      (tx_data),
        .empty     (tx_empty),
        .full      (tx_full)
    );
    assign tx_valid = !tx_empty;

    mbox_fifo #(.DATA_W(BYTE_W), .DEPTH(RX_DEPTH)) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_valid),
        .push_data (rx_data),
        .pop       (rd_data),
        .head      (rx_head),
        .empty     (rx_empty),
        .full      (rx_full)
    );

    // Sticky overflow: set by a byte lost to a full receive FIFO, cleared by
    // a status write of 1; a new loss in the same cycle keeps it set.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf_flag <= 1'b0;
        else if (rx_valid && rx_full)
            ovf_flag <= 1'b1;
        else if (wr_stat && bus_wdata[SRC_OVF])
            ovf_flag <= 1'b0;
    end

    assign cond[SRC_TXE]  = tx_empty;
    assign cond[SRC_TXNF] = !tx_full;
    assign cond[SRC_RXNE] = !rx_empty;
    assign cond[SRC_OVF]  = ovf_flag;

    // Request clears come from write-one bits of either control register.
    always_comb begin
        clr = '0;
        if (wr_int)  clr = clr | bus_wdata[NUM_SRC-1:0];
        if (wr_stat) clr = clr | bus_wdata[NUM_SRC-1:0];
    end

    mbox_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .cond    (cond),
        .clr     (clr),
        .mask_we (wr_int),
        .mask_in (bus_wdata[2*NUM_SRC-1:NUM_SRC]),
        .req_o   (req),
        .mask_o  (mask),
        .irq_o   (irq)
    );

    // Read multiplexer; reserved words and idle cycles return zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (word_idx)
                W_INTCTL: bus_rdata[2*NUM_SRC-1:0] = {mask, req};
                W_DATA:   if (!rx_empty) bus_rdata[BYTE_LSB +: BYTE_W] = rx_head;
                W_STATUS: bus_rdata[NUM_SRC-1:0] = cond;
                default:  bus_rdata = '0;
            endcase
        end
    end

    // R6: the overflow flag holds until a status write clears it.
    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !(wr_stat && bus_wdata[SRC_OVF])) |=> ovf_flag);

    // R2: an offered transmit byte stays put until it is taken.
    p_tx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R4: a data read with nothing received returns zero.
    p_empty_read_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && rx_empty) |-> (bus_rdata == '0));

    // R5: the status word never carries bits above the four conditions.
    p_status_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && word_idx == W_STATUS) |-> (bus_rdata[BUS_W-1:NUM_SRC] == '0));
endmodule

// File: tb/mbox_regif_bench.sv
// Self-checking bench for the mailbox register interface.
module mbox_regif_bench;
    localparam int PERIOD = 10;
    localparam int DEPTH  = 8;
    localparam logic [4:0] A_INT = 5'h00, A_DAT = 5'h04, A_STA = 5'h08;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, tx_valid, tx_ready = 1'b0, rx_valid = 1'b0;
    logic [7:0]  tx_data, rx_data = '0;

    int checks = 0;
    int errors = 0;
    logic [31:0] rv;

    always #(PERIOD/2) clk = ~clk;

    mbox_regif u_mbox_regif (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic rx_send(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        @(posedge clk); #1;
        rx_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    function automatic logic [7:0] txb(input int i);
        return 8'(i * 37 + 5);
    endfunction

    function automatic logic [7:0] rxb(input int i);
        return 8'(i * 53 + 11);
    endfunction

    initial begin
        #(PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(3);

        // R10: reset state, no request from the reset conditions
        rd(A_INT, rv); chk("R10 intctl after reset", rv, 32'h0);
        rd(A_STA, rv); chk("R10 status after reset", rv, 32'h3);
        chk("R10 irq low", {31'b0, irq}, 32'h0);
        chk("R10 tx_valid low", {31'b0, tx_valid}, 32'h0);

        // R1: reserved words read zero, writes there change nothing
        for (int w = 3; w < 8; w++) begin
            wr(5'(w * 4), 32'hFFFF_FFFF);
            rd(5'(w * 4), rv); chk("R1 reserved reads zero", rv, 32'h0);
        end
        rd(A_INT, rv); chk("R1 reserved write left intctl", rv, 32'h0);
        rd(A_STA, rv); chk("R1 reserved write left status", rv, 32'h3);

        // R2/R3/R5: fill transmit FIFO beyond depth, status tracks count
        for (int k = 0; k < DEPTH + 2; k++) begin
            wr(A_DAT, {16'hFFFF, txb(k), 8'hFF});
            rd(A_STA, rv);
            chk("R5 status while filling tx", rv,
                {30'b0, (k + 1 < DEPTH), 1'b0});
        end
        // R7: both transmit requests stay clear (conditions fell, never rose)
        rd(A_INT, rv); chk("R7 no tx request on falling", rv, 32'h0);

        // R2/R3: drain in order; extra writes were dropped
        for (int k = 0; k < DEPTH; k++) begin
            @(negedge clk);
            chk("R2 tx_valid while draining", {31'b0, tx_valid}, 32'h1);
            chk("R3 tx byte order", {24'b0, tx_data}, {24'b0, txb(k)});
            tx_ready = 1'b1;
            @(posedge clk); #1;
            tx_ready = 1'b0;
        end
        @(negedge clk);
        chk("R3 tx empty after depth bytes", {31'b0, tx_valid}, 32'h0);
        idle(2);
        // R7: empty and not-full rose during the drain
        rd(A_INT, rv); chk("R7 tx requests latched", rv, 32'h3);

        // R4/R6: push past receive depth
        rx_send(rxb(0));
        idle(2);
        rd(A_INT, rv); chk("R7 rx request latched", rv, 32'h7);
        for (int k = 1; k < DEPTH + 2; k++) rx_send(rxb(k));
        idle(2);
        rd(A_STA, rv); chk("R6 overflow in status", rv, 32'hF);
        rd(A_INT, rv); chk("R7 all requests", rv, 32'hF);

        // R9: sweep all mask values with all requests set
        for (int m = 0; m < 16; m++) begin
            wr(A_INT, {24'b0, 4'(m), 4'b0000});
            rd(A_INT, rv);
            chk("R9 mask readback", rv, {24'b0, 4'(m), 4'hF});
            chk("R9 irq vs mask", {31'b0, irq}, {31'b0, (m != 0)});
        end

        // R4: read back the stored bytes, overflowed ones are gone
        for (int k = 0; k < DEPTH; k++) begin
            rd(A_DAT, rv);
            chk("R4 rx byte", rv, {16'b0, rxb(k), 8'b0});
        end
        rd(A_DAT, rv); chk("R4 empty read zero", rv, 32'h0);
        rd(A_STA, rv); chk("R6 overflow still set", rv, 32'hB);

        // R8: clear sources one at a time, irq follows masks (all on)
        wr(A_INT, 32'h0000_00F0);
        wr(A_STA, 32'h0000_0004);
        rd(A_INT, rv); chk("R8 ack clears rx request", rv, 32'hFB);
        wr(A_INT, 32'h0000_00F1);
        rd(A_INT, rv); chk("R8 intctl clear bit0", rv, 32'hFA);
        wr(A_STA, 32'h0000_0002);
        rd(A_INT, rv); chk("R8 status clear bit1", rv, 32'hF8);
        chk("R9 irq with overflow request", {31'b0, irq}, 32'h1);
        wr(A_STA, 32'h0000_0008);
        idle(2);
        rd(A_STA, rv); chk("R6 overflow cleared", rv, 32'h3);
        rd(A_INT, rv); chk("R8 overflow request cleared", rv, 32'hF0);
        chk("R9 irq low with no requests", {31'b0, irq}, 32'h0);

        // R8: ack while bytes remain does not relatch
        rx_send(8'h5A); rx_send(8'hC3);
        idle(2);
        wr(A_STA, 32'h0000_0004);
        rd(A_DAT, rv); chk("R4 first of pair", rv, 32'h0000_5A00);
        idle(2);
        rd(A_INT, rv); chk("R8 no relatch while nonempty", rv, 32'hF0);
        rd(A_DAT, rv); chk("R4 second of pair", rv, 32'h0000_C300);

        // R10: reset mid-run clears everything
        rx_send(8'h77);
        wr(A_DAT, 32'h0000_1200);
        @(negedge clk); rst_n = 1'b0;
        idle(2);
        @(negedge clk); rst_n = 1'b1;
        idle(2);
        rd(A_INT, rv); chk("R10 intctl after second reset", rv, 32'h0);
        rd(A_STA, rv); chk("R10 status after second reset", rv, 32'h3);
        rd(A_DAT, rv); chk("R10 rx empty after reset", rv, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule